// File: doc/BRIEF.md
# Interrupt Priority Resolver

This block decides which interrupt request the processor takes next. Five special sources sit at the top and two low special sources (single step, address match) sit at the bottom, each in a fixed hardware order. Between them are `N_PER` maskable peripheral sources, each with a 3-bit level that software programs. Every request is held in a pending latch. At each instruction boundary the block picks one winner. It then emits a one-cycle acknowledge that carries the vector number, the level, and the flag word and program counter to be saved.

Software interrupts skip arbitration completely. On return from a handler the saved flag word and program counter are presented in one strobe. The block restores the processor level and the enable flag from that word and reports the resume address. The processor level and the enable flag live inside the block. Software can also write them directly.

Top module: `irq_prio_resolver`

## Requirements
- R1: After reset no source is pending, the processor level is 0, the enable flag is 0, and `ack_o` and `resume_o` are low.
- R2: A request pulse sets the source's pending bit. The bit stays set until that source is acknowledged or cleared by `per_clr_i`, so a request that loses arbitration is taken later.
- R3: Arbitration uses the pending bits held before the boundary cycle. The acknowledge is a one-cycle pulse in the cycle after `boundary_i` is high, and it clears the winner's pending bit. A request pulsed in the boundary cycle itself waits for a later boundary.
- R4: Fixed order among sources. `hi_req_i` bit 0 is highest and bit 4 is lowest, and bit k gives vector k. Any high special source beats every peripheral. Peripherals beat `lo_req_i` bit 0 (single step, vector 5), which beats `lo_req_i` bit 1 (address match, vector 6).
- R5: Among peripherals the highest programmed level wins, and equal levels go to the lower index. Peripheral i has vector 16+i and its level in `per_lvl_i[3i+2:3i]`. Level 0 never wins.
- R6: A peripheral is eligible only when the enable flag is 1 and its level is strictly above the processor level. Special sources ignore both conditions.
- R7: A hardware acknowledge does the following:
  - `ack_lvl_o` is the peripheral's level, or 7 for any special source, and the processor level takes that value.
  - `ctx_flg_o` is the flag word from before the acknowledge: bit 3 is the enable flag, bits 2:0 are the level.
  - `ctx_pc_o` is the value `pc_i` had in the boundary cycle.
- R8: `sw_req_i` is acknowledged in the next cycle whatever `boundary_i`, the masks and the pending sources are. Its vector is 64+`sw_num_i` and its level is the current processor level, which does not change. Hardware sources remain pending.
- R9: `reti_i` produces `resume_o` and `resume_pc_o` = `rest_pc_i` in the next cycle, and loads the level and enable flag from `rest_flg_i`, laid out as in R7. The same cycle's `sw_req_i` and `boundary_i` are dropped, and no acknowledge is produced.
- R10: `flg_we_i` loads the level and enable flag from `flg_wdata_i` (laid out as in R7), but only in a cycle that produces neither an acknowledge nor a resume. Otherwise it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hi_req_i | input | 5 | High special request pulses (bit 0 highest) |
| lo_req_i | input | 2 | Single-step (bit 0) and address-match (bit 1) request pulses |
| per_req_i | input | N_PER | Peripheral request pulses |
| per_clr_i | input | N_PER | Software clear of peripheral pending bits |
| per_lvl_i | input | N_PER*LVL_W | Programmed peripheral levels |
| boundary_i | input | 1 | Instruction boundary strobe |
| pc_i | input | PC_W | Current program counter |
| sw_req_i | input | 1 | Software interrupt strobe |
| sw_num_i | input | SWN_W | Software interrupt number |
| reti_i | input | 1 | Return-from-interrupt strobe |
| rest_flg_i | input | LVL_W+1 | Flag word popped on return |
| rest_pc_i | input | PC_W | Program counter popped on return |
| flg_we_i | input | 1 | Direct flag write strobe |
| flg_wdata_i | input | LVL_W+1 | Direct flag write data |
| ack_o | output | 1 | Acknowledge pulse |
| ack_vec_o | output | VEC_W | Acknowledged vector number |
| ack_lvl_o | output | LVL_W | Acknowledged level |
| ctx_flg_o | output | LVL_W+1 | Flag word to save |
| ctx_pc_o | output | PC_W | Program counter to save |
| resume_o | output | 1 | Return completed pulse |
| resume_pc_o | output | PC_W | Address to resume at |
| ipl_o | output | LVL_W | Current processor level |
| ien_o | output | 1 | Current enable flag |

## Verification
The bench goes after the following corner cases:
- **Equal levels.** Two peripherals share a level, and the one with the higher index must still be pending and win once the processor level drops. A resolver that lets the last index win, or drops the loser, acknowledges the wrong vector here.
- **Level 0 and strictness.** A level-0 source is left pending forever, and a source whose level equals the processor level is left waiting. An off-by-one compare produces an acknowledge where none is due.
- **Collisions.** Return, software interrupt and boundary are driven in the same cycle. Flag writes are driven into acknowledge cycles. Requests are pulsed into the boundary cycle itself. A wrong precedence shows up as a spurious acknowledge, a lost resume, or a processor level that is off.
- **Random traffic.** A long random run is compared against a behavioural model on every clock.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
   localparam int NUM_HI = 5;
   localparam int NUM_LO = 2;
   localparam int LO_BASE = NUM_HI;

   typedef enum logic [1:0] {
      SRC_NONE,
      SRC_HI,
      SRC_PER,
      SRC_LO
   } src_e;
endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] set_i,
   input  logic [WIDTH-1:0] clr_i,
   output logic [WIDTH-1:0] pend_o
);
   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("irq_pend_bank: WIDTH must be at least 1");
      end
   endgenerate

   // set has priority over clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_o <= '0;
      else        pend_o <= set_i | (pend_o & ~clr_i);
   end

   generate
      for (genvar g = 0; g < WIDTH; g++) begin : g_chk
         AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(pend_o[g]) && !$past(clr_i[g])) |-> pend_o[g]); // R2
      end
   endgenerate
endmodule

// File: rtl/irq_lvl_pick.sv
module irq_lvl_pick #(
   parameter int N_PER = 8,
   parameter int LVL_W = 3,
   localparam int IDX_W = (N_PER > 1) ? $clog2(N_PER) : 1
) (
   input  logic [N_PER-1:0]       pend_i,
   input  logic [N_PER*LVL_W-1:0] lvl_i,
   input  logic [LVL_W-1:0]       ipl_i,
   input  logic                   ien_i,
   output logic                   found_o,
   output logic [IDX_W-1:0]       idx_o,
   output logic [LVL_W-1:0]       lvl_o
);
   // linear scan: strict compare keeps the lowest index on a tie,
   // and starting from 0 keeps level 0 out
   always_comb begin
      found_o = 1'b0;
      idx_o   = '0;
      lvl_o   = '0;
      for (int i = 0; i < N_PER; i++) begin
         if (ien_i && pend_i[i] &&
             (lvl_i[i*LVL_W +: LVL_W] > ipl_i) &&
             (lvl_i[i*LVL_W +: LVL_W] > lvl_o)) begin
            found_o = 1'b1;
            idx_o   = IDX_W'(i);
            lvl_o   = lvl_i[i*LVL_W +: LVL_W];
         end
      end
   end
endmodule

// File: rtl/irq_seq.sv
module irq_seq
   import irq_arb_pkg::*;
#(
   parameter int N_PER    = 8,
   parameter int LVL_W    = 3,
   parameter int PC_W     = 16,
   parameter int SWN_W    = 6,
   parameter int VEC_W    = 8,
   parameter int PER_BASE = 16,
   parameter int SW_BASE  = 64,
   localparam int IDX_W   = (N_PER > 1) ? $clog2(N_PER) : 1,
   localparam int FLG_W   = LVL_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              boundary_i,
   input  logic              sw_req_i,
   input  logic [SWN_W-1:0]  sw_num_i,
   input  logic              reti_i,
   input  logic [FLG_W-1:0]  rest_flg_i,
   input  logic [PC_W-1:0]   rest_pc_i,
   input  logic              flg_we_i,
   input  logic [FLG_W-1:0]  flg_wdata_i,
   input  logic [PC_W-1:0]   pc_i,
   input  logic [NUM_HI-1:0] hi_pend_i,
   input  logic [NUM_LO-1:0] lo_pend_i,
   input  logic              per_found_i,
   input  logic [IDX_W-1:0]  per_idx_i,
   input  logic [LVL_W-1:0]  per_lvl_i,
   output logic [NUM_HI-1:0] hi_clr_o,
   output logic [NUM_LO-1:0] lo_clr_o,
   output logic [N_PER-1:0]  per_clr_o,
   output logic              ack_o,
   output logic [VEC_W-1:0]  ack_vec_o,
   output logic [LVL_W-1:0]  ack_lvl_o,
   output logic [FLG_W-1:0]  ctx_flg_o,
   output logic [PC_W-1:0]   ctx_pc_o,
   output logic              resume_o,
   output logic [PC_W-1:0]   resume_pc_o,
   output logic [LVL_W-1:0]  ipl_o,
   output logic              ien_o
);
   localparam logic [VEC_W-1:0] PER_LO = VEC_W'(PER_BASE);
   localparam logic [VEC_W-1:0] PER_HI = VEC_W'(PER_BASE + N_PER);
   localparam logic [VEC_W-1:0] SW_LO  = VEC_W'(SW_BASE);

   src_e             win;
   logic [VEC_W-1:0] win_vec;
   logic [LVL_W-1:0] win_lvl;
   logic             hw_slot;

   assign hw_slot = boundary_i & ~reti_i & ~sw_req_i;

   // later assignments override: low specials, then peripheral, then high
   always_comb begin
      win     = SRC_NONE;
      win_vec = '0;
      win_lvl = '1;
      for (int k = NUM_LO-1; k >= 0; k--) begin
         if (lo_pend_i[k]) begin
            win     = SRC_LO;
            win_vec = VEC_W'(LO_BASE + k);
         end
      end
      if (per_found_i) begin
         win     = SRC_PER;
         win_vec = PER_LO + VEC_W'(per_idx_i);
         win_lvl = per_lvl_i;
      end
      for (int k = NUM_HI-1; k >= 0; k--) begin
         if (hi_pend_i[k]) begin
            win     = SRC_HI;
            win_vec = VEC_W'(k);
            win_lvl = '1;
         end
      end
   end

   always_comb begin
      hi_clr_o  = '0;
      lo_clr_o  = '0;
      per_clr_o = '0;
      if (hw_slot) begin
         case (win)
            SRC_HI:  hi_clr_o  = NUM_HI'(1) << win_vec;
            SRC_LO:  lo_clr_o  = NUM_LO'(1) << (win_vec - VEC_W'(LO_BASE));
            SRC_PER: per_clr_o = N_PER'(1) << per_idx_i;
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_o       <= 1'b0;
         ack_vec_o   <= '0;
         ack_lvl_o   <= '0;
         ctx_flg_o   <= '0;
         ctx_pc_o    <= '0;
         resume_o    <= 1'b0;
         resume_pc_o <= '0;
         ipl_o       <= '0;
         ien_o       <= 1'b0;
      end else begin
         ack_o    <= 1'b0;
         resume_o <= 1'b0;
         if (reti_i) begin
            resume_o    <= 1'b1;
            resume_pc_o <= rest_pc_i;
            ipl_o       <= rest_flg_i[LVL_W-1:0];
            ien_o       <= rest_flg_i[LVL_W];
         end else if (sw_req_i) begin
            ack_o     <= 1'b1;
            ack_vec_o <= SW_LO + VEC_W'(sw_num_i);
            ack_lvl_o <= ipl_o;
            ctx_flg_o <= {ien_o, ipl_o};
            ctx_pc_o  <= pc_i;
         end else if (hw_slot && win != SRC_NONE) begin
            ack_o     <= 1'b1;
            ack_vec_o <= win_vec;
            ack_lvl_o <= win_lvl;
            ctx_flg_o <= {ien_o, ipl_o};
            ctx_pc_o  <= pc_i;
            ipl_o     <= win_lvl;
         end else if (flg_we_i) begin
            ipl_o <= flg_wdata_i[LVL_W-1:0];
            ien_o <= flg_wdata_i[LVL_W];
         end
      end
   end

   AST_HW_ACK_SETS_IPL: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_o && ack_vec_o < SW_LO) |-> (ipl_o == ack_lvl_o)); // R7
   AST_PER_ABOVE_IPL: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_o && ack_vec_o >= PER_LO && ack_vec_o < PER_HI)
         |-> (ack_lvl_o > $past(ipl_o) && $past(ien_o))); // R6
   AST_SW_KEEPS_IPL: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_o && ack_vec_o >= SW_LO) |-> (ipl_o == $past(ipl_o))); // R8
   AST_RESUME_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      resume_o |-> !ack_o); // R9
   AST_RESUME_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      resume_o |-> ({ien_o, ipl_o} == $past(rest_flg_i))); // R9
endmodule

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver
   import irq_arb_pkg::*;
#(
   parameter int N_PER    = 8,
   parameter int LVL_W    = 3,
   parameter int PC_W     = 16,
   parameter int SWN_W    = 6,
   parameter int VEC_W    = 8,
   parameter int PER_BASE = 16,
   parameter int SW_BASE  = 64,
   localparam int IDX_W   = (N_PER > 1) ? $clog2(N_PER) : 1,
   localparam int FLG_W   = LVL_W + 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_HI-1:0]      hi_req_i,
   input  logic [NUM_LO-1:0]      lo_req_i,
   input  logic [N_PER-1:0]       per_req_i,
   input  logic [N_PER-1:0]       per_clr_i,
   input  logic [N_PER*LVL_W-1:0] per_lvl_i,
   input  logic                   boundary_i,
   input  logic [PC_W-1:0]        pc_i,
   input  logic                   sw_req_i,
   input  logic [SWN_W-1:0]       sw_num_i,
   input  logic                   reti_i,
   input  logic [FLG_W-1:0]       rest_flg_i,
   input  logic [PC_W-1:0]        rest_pc_i,
   input  logic                   flg_we_i,
   input  logic [FLG_W-1:0]       flg_wdata_i,
   output logic                   ack_o,
   output logic [VEC_W-1:0]       ack_vec_o,
   output logic [LVL_W-1:0]       ack_lvl_o,
   output logic [FLG_W-1:0]       ctx_flg_o,
   output logic [PC_W-1:0]        ctx_pc_o,
   output logic                   resume_o,
   output logic [PC_W-1:0]        resume_pc_o,
   output logic [LVL_W-1:0]       ipl_o,
   output logic                   ien_o
);
   generate
      if (N_PER < 1 || LVL_W < 1 || PC_W < 1 || SWN_W < 1) begin : g_bad_size
         $error("irq_prio_resolver: sizes must be positive");
      end
      if (PER_BASE < NUM_HI + NUM_LO || PER_BASE + N_PER > SW_BASE) begin : g_bad_map
         $error("irq_prio_resolver: peripheral vectors overlap another range");
      end
      if (SW_BASE + (1 << SWN_W) > (1 << VEC_W)) begin : g_bad_vec
         $error("irq_prio_resolver: VEC_W too narrow for software vectors");
      end
   endgenerate

   logic [NUM_HI-1:0] hi_pend, hi_clr;
   logic [NUM_LO-1:0] lo_pend, lo_clr;
   logic [N_PER-1:0]  per_pend, per_take;
   logic              per_found;
   logic [IDX_W-1:0]  per_idx;
   logic [LVL_W-1:0]  per_lvl;

   irq_pend_bank #(.WIDTH(NUM_HI)) i_hi_bank (
      .clk(clk), .rst_n(rst_n), .set_i(hi_req_i), .clr_i(hi_clr), .pend_o(hi_pend));

   irq_pend_bank #(.WIDTH(NUM_LO)) i_lo_bank (
      .clk(clk), .rst_n(rst_n), .set_i(lo_req_i), .clr_i(lo_clr), .pend_o(lo_pend));

   irq_pend_bank #(.WIDTH(N_PER)) i_per_bank (
      .clk(clk), .rst_n(rst_n), .set_i(per_req_i), .clr_i(per_take | per_clr_i),
      .pend_o(per_pend));

   irq_lvl_pick #(.N_PER(N_PER), .LVL_W(LVL_W)) i_pick (
      .pend_i(per_pend), .lvl_i(per_lvl_i), .ipl_i(ipl_o), .ien_i(ien_o),
      .found_o(per_found), .idx_o(per_idx), .lvl_o(per_lvl));

   irq_seq #(
      .N_PER(N_PER), .LVL_W(LVL_W), .PC_W(PC_W), .SWN_W(SWN_W),
      .VEC_W(VEC_W), .PER_BASE(PER_BASE), .SW_BASE(SW_BASE)
   ) i_seq (
      .clk(clk), .rst_n(rst_n),
      .boundary_i(boundary_i), .sw_req_i(sw_req_i), .sw_num_i(sw_num_i),
      .reti_i(reti_i), .rest_flg_i(rest_flg_i), .rest_pc_i(rest_pc_i),
      .flg_we_i(flg_we_i), .flg_wdata_i(flg_wdata_i), .pc_i(pc_i),
      .hi_pend_i(hi_pend), .lo_pend_i(lo_pend),
      .per_found_i(per_found), .per_idx_i(per_idx), .per_lvl_i(per_lvl),
      .hi_clr_o(hi_clr), .lo_clr_o(lo_clr), .per_clr_o(per_take),
      .ack_o(ack_o), .ack_vec_o(ack_vec_o), .ack_lvl_o(ack_lvl_o),
      .ctx_flg_o(ctx_flg_o), .ctx_pc_o(ctx_pc_o),
      .resume_o(resume_o), .resume_pc_o(resume_pc_o),
      .ipl_o(ipl_o), .ien_o(ien_o));

   AST_SPECIAL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_o && ack_vec_o >= VEC_W'(PER_BASE) && ack_vec_o < VEC_W'(PER_BASE + N_PER))
         |-> ($past(hi_pend) == '0)); // R4
endmodule

// File: tb/test_irq_prio_resolver.sv
module test_irq_prio_resolver;
   localparam int CLK_PERIOD = 10;
   localparam int NP = 8;
   localparam int LW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [4:0]    hi_req = '0;
   logic [1:0]    lo_req = '0;
   logic [NP-1:0] per_req = '0, per_clr = '0;
   logic [NP*LW-1:0] per_lvl = '0;
   logic          boundary = 1'b0;
   logic [15:0]   pc = 16'h1234;
   logic          sw_req = 1'b0;
   logic [5:0]    sw_num = '0;
   logic          reti = 1'b0;
   logic [3:0]    rest_flg = '0;
   logic [15:0]   rest_pc = '0;
   logic          flg_we = 1'b0;
   logic [3:0]    flg_wdata = '0;
   logic          ack_o, resume_o, ien_o;
   logic [7:0]    ack_vec_o;
   logic [2:0]    ack_lvl_o, ipl_o;
   logic [3:0]    ctx_flg_o;
   logic [15:0]   ctx_pc_o, resume_pc_o;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_prio_resolver i_irq_prio_resolver (
      .clk(clk), .rst_n(rst_n), .hi_req_i(hi_req), .lo_req_i(lo_req),
      .per_req_i(per_req), .per_clr_i(per_clr), .per_lvl_i(per_lvl),
      .boundary_i(boundary), .pc_i(pc), .sw_req_i(sw_req), .sw_num_i(sw_num),
      .reti_i(reti), .rest_flg_i(rest_flg), .rest_pc_i(rest_pc),
      .flg_we_i(flg_we), .flg_wdata_i(flg_wdata),
      .ack_o(ack_o), .ack_vec_o(ack_vec_o), .ack_lvl_o(ack_lvl_o),
      .ctx_flg_o(ctx_flg_o), .ctx_pc_o(ctx_pc_o), .resume_o(resume_o),
      .resume_pc_o(resume_pc_o), .ipl_o(ipl_o), .ien_o(ien_o));

   task automatic chk(string tag, int got, int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d at %0t", tag, got, exp, $time);
      end
   endtask

   // behavioural reference model
   bit m_hi[5], m_lo[2], m_per[NP];
   int m_ipl, m_ien, m_ack, m_vec, m_lvl, m_cflg, m_cpc, m_res, m_rpc;

   function automatic int lvl_of(int i);
      return int'(per_lvl[i*LW +: LW]);
   endfunction

   always @(posedge clk) begin : p_model
      int wv, wl, best, bl;
      bit wf;
      if (!rst_n) begin
         foreach (m_hi[k]) m_hi[k] = 0;
         foreach (m_lo[k]) m_lo[k] = 0;
         foreach (m_per[k]) m_per[k] = 0;
         m_ipl = 0; m_ien = 0; m_ack = 0; m_vec = 0; m_lvl = 0;
         m_cflg = 0; m_cpc = 0; m_res = 0; m_rpc = 0;
      end else begin
         m_ack = 0; m_res = 0;
         if (reti) begin
            m_res = 1; m_rpc = rest_pc;
            m_ipl = rest_flg[2:0]; m_ien = rest_flg[3];
         end else if (sw_req) begin
            m_ack = 1; m_vec = 64 + sw_num; m_lvl = m_ipl;
            m_cflg = m_ien * 8 + m_ipl; m_cpc = pc;
         end else if (boundary) begin
            wf = 0; wv = 0; wl = 7;
            for (int k = 0; k < 5; k++)
               if (!wf && m_hi[k]) begin wf = 1; wv = k; wl = 7; m_hi[k] = 0; end
            if (!wf) begin
               best = -1; bl = 0;
               for (int i = 0; i < NP; i++)
                  if (m_per[i] && m_ien == 1 && lvl_of(i) > m_ipl && lvl_of(i) > bl) begin
                     best = i; bl = lvl_of(i);
                  end
               if (best >= 0) begin wf = 1; wv = 16 + best; wl = bl; m_per[best] = 0; end
            end
            for (int k = 0; k < 2; k++)
               if (!wf && m_lo[k]) begin wf = 1; wv = 5 + k; wl = 7; m_lo[k] = 0; end
            if (wf) begin
               m_ack = 1; m_vec = wv; m_lvl = wl;
               m_cflg = m_ien * 8 + m_ipl; m_cpc = pc; m_ipl = wl;
            end
         end
         if (!m_ack && !m_res && flg_we) begin
            m_ipl = flg_wdata[2:0]; m_ien = flg_wdata[3];
         end
         for (int i = 0; i < NP; i++) if (per_clr[i]) m_per[i] = 0;
         for (int k = 0; k < 5; k++) if (hi_req[k]) m_hi[k] = 1;
         for (int k = 0; k < 2; k++) if (lo_req[k]) m_lo[k] = 1;
         for (int i = 0; i < NP; i++) if (per_req[i]) m_per[i] = 1;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R3 model ack", int'(ack_o), m_ack);
         chk("R9 model resume", int'(resume_o), m_res);
         chk("R7 model ipl", int'(ipl_o), m_ipl);
         chk("R10 model ien", int'(ien_o), m_ien);
         if (m_ack == 1) begin
            chk("R4 R5 model vec", int'(ack_vec_o), m_vec);
            chk("R7 model lvl", int'(ack_lvl_o), m_lvl);
            chk("R7 model ctx_flg", int'(ctx_flg_o), m_cflg);
            chk("R7 model ctx_pc", int'(ctx_pc_o), m_cpc);
         end
         if (m_res == 1) chk("R9 model resume_pc", int'(resume_pc_o), m_rpc);
      end
   end

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic clear_pulses();
      hi_req = '0; lo_req = '0; per_req = '0; per_clr = '0; boundary = 0;
      sw_req = 0; reti = 0; flg_we = 0;
   endtask

   task automatic wr_flags(logic [3:0] v);
      flg_we = 1; flg_wdata = v; tick(); clear_pulses();
   endtask

   task automatic bnd();
      boundary = 1; tick(); clear_pulses();
   endtask

   task automatic exp_ack(string tag, int vec, int lvl);
      chk({tag, " ack"}, int'(ack_o), 1);
      chk({tag, " vec"}, int'(ack_vec_o), vec);
      chk({tag, " lvl"}, int'(ack_lvl_o), lvl);
   endtask

   initial begin : p_watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL watchdog actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin : p_main
      per_lvl[0*LW +: LW] = 3'd2;
      per_lvl[3*LW +: LW] = 3'd5;
      per_lvl[5*LW +: LW] = 3'd5;
      per_lvl[6*LW +: LW] = 3'd0;
      repeat (3) tick();
      rst_n = 1;
      tick();
      // R1 reset state
      chk("R1 ack", int'(ack_o), 0);
      chk("R1 resume", int'(resume_o), 0);
      chk("R1 ipl", int'(ipl_o), 0);
      chk("R1 ien", int'(ien_o), 0);
      wr_flags(4'b1000);
      chk("R10 ien write", int'(ien_o), 1);
      bnd();
      chk("R1 nothing pending", int'(ack_o), 0);

      // R5 levels and ties
      per_req = 8'b0110_1001; tick(); clear_pulses();
      bnd();
      exp_ack("R5 highest level", 19, 5);
      chk("R7 ipl raised", int'(ipl_o), 5);
      chk("R7 ctx_flg", int'(ctx_flg_o), 8);
      chk("R7 ctx_pc", int'(ctx_pc_o), 16'h1234);
      tick();
      chk("R3 one-cycle pulse", int'(ack_o), 0);
      bnd();
      chk("R6 equal to ipl blocked", int'(ack_o), 0);
      wr_flags(4'b1001);
      bnd();
      exp_ack("R2 R5 tie loser kept", 21, 5);
      wr_flags(4'b1001);
      bnd();
      exp_ack("R5 lower level later", 16, 2);
      wr_flags(4'b1000);
      bnd();
      chk("R5 level zero never", int'(ack_o), 0);

      // R6 enable flag, R4 fixed order
      per_req[0] = 1; flg_we = 1; flg_wdata = 4'b0000; tick(); clear_pulses();
      bnd();
      chk("R6 ien clear blocks", int'(ack_o), 0);
      hi_req = 5'b00101; lo_req = 2'b11; tick(); clear_pulses();
      bnd(); exp_ack("R4 R6 top special", 0, 7);
      chk("R7 ipl special", int'(ipl_o), 7);
      bnd(); exp_ack("R4 second special", 2, 7);
      bnd(); exp_ack("R4 single step", 5, 7);
      bnd(); exp_ack("R4 address match", 6, 7);
      bnd(); chk("R4 drained", int'(ack_o), 0);
      lo_req[0] = 1; flg_we = 1; flg_wdata = 4'b1000; tick(); clear_pulses();
      bnd(); exp_ack("R4 peripheral over single step", 16, 2);
      bnd(); exp_ack("R4 single step after", 5, 7);

      // R2 software clear
      per_req[3] = 1; tick(); clear_pulses();
      per_clr[3] = 1; tick(); clear_pulses();
      wr_flags(4'b1000);
      bnd();
      chk("R2 cleared by software", int'(ack_o), 0);

      // R8 software interrupt
      per_req[3] = 1; tick(); clear_pulses();
      boundary = 1; sw_req = 1; sw_num = 6'd9; tick(); clear_pulses();
      exp_ack("R8 software", 73, 0);
      chk("R8 ipl unchanged", int'(ipl_o), 0);
      bnd();
      exp_ack("R8 hw kept pending", 19, 5);

      // R9 return
      per_req[3] = 1; tick(); clear_pulses();
      reti = 1; rest_flg = 4'b1010; rest_pc = 16'hBEEF; boundary = 1; sw_req = 1;
      tick(); clear_pulses();
      chk("R9 resume", int'(resume_o), 1);
      chk("R9 resume_pc", int'(resume_pc_o), 16'hBEEF);
      chk("R9 no ack", int'(ack_o), 0);
      chk("R9 ipl restored", int'(ipl_o), 2);
      chk("R9 ien restored", int'(ien_o), 1);
      bnd();
      exp_ack("R9 hw kept", 19, 5);

      // R10 write ignored on ack
      wr_flags(4'b1000);
      per_req[0] = 1; tick(); clear_pulses();
      boundary = 1; flg_we = 1; flg_wdata = 4'b1111; tick(); clear_pulses();
      exp_ack("R10 ack wins", 16, 2);
      chk("R10 write ignored", int'(ipl_o), 2);

      // R3 request in the boundary cycle waits
      wr_flags(4'b1000);
      per_req[0] = 1; boundary = 1; tick(); clear_pulses();
      chk("R3 same-cycle request waits", int'(ack_o), 0);
      bnd();
      exp_ack("R3 later boundary", 16, 2);

      // random traffic against the model
      for (int i = 0; i < NP; i++) per_lvl[i*LW +: LW] = 3'($urandom_range(0, 7));
      for (int n = 0; n < 4000; n++) begin
         hi_req   = ($urandom_range(0, 15) == 0) ? 5'($urandom) : '0;
         lo_req   = ($urandom_range(0, 7) == 0) ? 2'($urandom) : '0;
         per_req  = ($urandom_range(0, 2) == 0) ? 8'($urandom) : '0;
         per_clr  = ($urandom_range(0, 9) == 0) ? 8'($urandom) : '0;
         boundary = ($urandom_range(0, 2) == 0);
         sw_req   = ($urandom_range(0, 30) == 0);
         sw_num   = 6'($urandom);
         reti     = ($urandom_range(0, 12) == 0);
         rest_flg = 4'($urandom);
         rest_pc  = 16'($urandom);
         flg_we   = ($urandom_range(0, 8) == 0);
         flg_wdata = 4'($urandom);
         pc       = 16'($urandom);
         tick();
      end
      clear_pulses();
      tick();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule